// File: doc/BRIEF.md
# Debug Read Access Engine

This block lets an external development tool read system memory without help from software. The tool programs an address register, then writes a control word. The control word carries a go flag, a memory-map selector, a bus priority, a direction bit, a transfer size and a 14-bit repeat count. The engine wins the bus through a request/grant handshake and marks the opening clock of the address phase with a one-cycle strobe. It then waits for the response, which is one outstanding transfer at a time. Each returned word goes into a data register, and the outcome is reported in three status bits (busy, data-valid, error) and on two active-low pins, one for ready and one for error.

With a repeat count above one, the engine reads a run of consecutive locations. After each good word the address steps by the transfer size in bytes and the count drops by one. The next transfer waits until the tool has collected the current word by reading the data register. A failed transfer ends the run at once and leaves the address and count pointing at the word that failed.

The controller has five states. IDLE waits for a go write: a legal setup takes the *launch* transition to REQ, and an illegal one takes the *reject* transition and stays in IDLE. REQ raises the bus request and moves to ADDR on *grant*. ADDR is the single strobe cycle and always moves on to DATA. DATA waits for the response: *fail* and *last* return to IDLE, and *more* goes to HOLD. HOLD waits for the tool's data read, and *resume* moves it to REQ.

Top module: `dbg_rd_engine`

## Requirements
- R1: After reset the busy, data-valid and error bits read 0, the data register reads 0, both pins are high, and neither the bus request nor the start strobe is active.
- R2: Register select 0 is the address register, 1 is the control word and 2 is the data register. The control word packs busy/go at bit 0, map at bits 3:1, priority at bits 5:4, direction at bit 6, size at bits 9:7, count at bits 23:10, data-valid at bit 30 and error at bit 31. A control write in IDLE stores the fields, and they read back unchanged.
- R3: A go write with direction 0 and a legal size raises the bus request. After grant, the start strobe is high for exactly one clock, while the bus shows the address, size, map and priority that were programmed.
- R4: On a good response the data register holds the returned word, data-valid is 1 and error is 0. The ready pin is low for exactly one clock, and the error pin stays high.
- R5: On an error response the error bit is 1, data-valid is 0 and busy is 0. The error pin is low for one clock, and the ready pin stays high.
- R6: A count of 0 or 1 performs exactly one transfer, after which busy reads 0.
- R7: A count N above 1 performs N transfers. Busy stays 1 until the last word. No new start strobe appears until the tool reads the data register, and that read clears data-valid.
- R8: Size 000 steps the address by 1, size 001 by 2 and size 010 by 4 after each good transfer. Each good transfer also lowers the count by one, stopping at 0.
- R9: An error in a run stops it. The address and count registers keep the values of the transfer that failed.
- R10: A go write with direction 1 or a size other than 000, 001 or 010 sets the error bit and pulses the error pin. No bus request is issued.
- R11: While an access is under way, writes to the address register and to the control word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Tool register write strobe |
| reg_rd_en | input | 1 | Tool register read strobe (has a side effect on the data register only) |
| reg_sel | input | 2 | Register select: 0 address, 1 control, 2 data |
| reg_wdata | input | 32 | Tool write data |
| reg_rdata | output | 32 | Register read data for the current select |
| bus_req | output | 1 | Bus request, held until the response |
| bus_gnt | input | 1 | Bus grant |
| bus_start | output | 1 | First-clock-of-address-phase strobe |
| bus_addr | output | 32 | Transfer address |
| bus_size | output | 2 | Transfer size: 0 byte, 1 halfword, 2 word |
| bus_map | output | 3 | Memory-map selector |
| bus_prio | output | 2 | Access priority |
| bus_done | input | 1 | Response valid |
| bus_err | input | 1 | Response is an error (qualified by bus_done) |
| bus_rdata | input | 32 | Response data |
| rdy_n | output | 1 | Ready pin, active low, one clock per good word |
| err_n | output | 1 | Error pin, active low, one clock per failure |

## Verification
Assertions watch every cycle for the rules that hold at all times:
- the start strobe never lasts more than a clock;
- the ready pulse lasts exactly one clock;
- the two pins are never low together, and each pin agrees with the status bits;
- the bus address holds while a response is pending;
- a failure leaves address and count untouched;
- a rejected setup raises no request.

Only the bench scenarios show the sequence-level behaviour: the addresses stepping through a run at each size, the number of transfers for a given count, the wait for the data read between words, the data values returned, and stores that arrive while busy being ignored.

// File: rtl/dbg_rd_pkg.sv
package dbg_rd_pkg;

    localparam int WORD_W = 32;

    // control word layout
    localparam int GO_BIT   = 0;
    localparam int MAP_LSB  = 1;
    localparam int MAP_W    = 3;
    localparam int PRI_LSB  = 4;
    localparam int PRI_W    = 2;
    localparam int DIR_BIT  = 6;
    localparam int SZ_LSB   = 7;
    localparam int SZ_W     = 3;
    localparam int CNT_LSB  = 10;
    localparam int DV_BIT   = 30;
    localparam int ERR_BIT  = 31;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_ADDR = 3'd2,
        ST_DATA = 3'd3,
        ST_HOLD = 3'd4
    } rd_state_e;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_DATA = 2'd2
    } reg_sel_e;

    function automatic logic size_legal(input logic [SZ_W-1:0] sz);
        return (sz == 3'b000) || (sz == 3'b001) || (sz == 3'b010);
    endfunction

endpackage

// File: rtl/dbg_rd_regs.sv
module dbg_rd_regs
    import dbg_rd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        sel,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic [WORD_W-1:0] resp_data,
    input  logic              idle,
    input  logic              ev_launch,
    input  logic              ev_reject,
    input  logic              ev_ok,
    input  logic              ev_fail,
    input  logic              ev_resume,
    output logic              start_req,
    output logic              cfg_ok,
    output logic              data_rd,
    output logic              cnt_more,
    output logic              ac_q,
    output logic              dv_q,
    output logic              er_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [SZ_W-1:0]   size_q,
    output logic [MAP_W-1:0]  map_q,
    output logic [PRI_W-1:0]  prio_q
);

    localparam int CNT_MSB = CNT_LSB + CNT_W - 1;

    logic              dir_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] data_q;
    logic [ADDR_W-1:0] step;
    logic              ctrl_wr, addr_wr;

    assign ctrl_wr   = wr_en && (sel == SEL_CTRL) && idle;
    assign addr_wr   = wr_en && (sel == SEL_ADDR) && idle;
    assign start_req = ctrl_wr && wdata[GO_BIT];
    assign cfg_ok    = size_legal(wdata[SZ_LSB +: SZ_W]) && !wdata[DIR_BIT];
    assign data_rd   = rd_en && (sel == SEL_DATA);
    assign cnt_more  = cnt_q > CNT_W'(1);
    assign step      = ADDR_W'(1) << size_q[1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (addr_wr) begin
            addr_q <= wdata[ADDR_W-1:0];
        end else if (ev_ok) begin
            addr_q <= addr_q + step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q  <= '0;
            prio_q <= '0;
            dir_q  <= 1'b0;
            size_q <= '0;
            cnt_q  <= '0;
        end else if (ctrl_wr) begin
            map_q  <= wdata[MAP_LSB +: MAP_W];
            prio_q <= wdata[PRI_LSB +: PRI_W];
            dir_q  <= wdata[DIR_BIT];
            size_q <= wdata[SZ_LSB +: SZ_W];
            cnt_q  <= wdata[CNT_MSB:CNT_LSB];
        end else if (ev_ok && (cnt_q != '0)) begin
            cnt_q  <= cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ac_q   <= 1'b0;
            dv_q   <= 1'b0;
            er_q   <= 1'b0;
            data_q <= '0;
        end else begin
            if (ev_launch) begin
                ac_q <= 1'b1;
                dv_q <= 1'b0;
                er_q <= 1'b0;
            end
            if (ev_reject || ev_fail) begin
                ac_q <= 1'b0;
                dv_q <= 1'b0;
                er_q <= 1'b1;
            end
            if (ev_ok) begin
                data_q <= resp_data;
                dv_q   <= 1'b1;
                er_q   <= 1'b0;
                if (!cnt_more) ac_q <= 1'b0;
            end
            if (ev_resume) dv_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_ADDR: rdata[ADDR_W-1:0] = addr_q;
            SEL_CTRL: begin
                rdata[GO_BIT]               = ac_q;
                rdata[MAP_LSB +: MAP_W]     = map_q;
                rdata[PRI_LSB +: PRI_W]     = prio_q;
                rdata[DIR_BIT]              = dir_q;
                rdata[SZ_LSB +: SZ_W]       = size_q;
                rdata[CNT_MSB:CNT_LSB]      = cnt_q;
                rdata[DV_BIT]               = dv_q;
                rdata[ERR_BIT]              = er_q;
            end
            SEL_DATA: rdata = data_q;
            default:  rdata = '0;
        endcase
    end

    // R9: a failing transfer leaves address and count where they were
    a_r9_fail_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        ev_fail |=> ($stable(addr_q) && $stable(cnt_q)));

    // R11: an access in progress blocks tool stores to address
    a_r11_busy_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !ev_ok) |=> $stable(addr_q));

    a_r4_dv_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(dv_q && er_q));

endmodule

// File: rtl/dbg_rd_fsm.sv
module dbg_rd_fsm
    import dbg_rd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_req,
    input  logic      cfg_ok,
    input  logic      cnt_more,
    input  logic      data_rd,
    input  logic      bus_gnt,
    input  logic      bus_done,
    input  logic      bus_err,
    output rd_state_e state,
    output logic      idle,
    output logic      bus_req,
    output logic      bus_start,
    output logic      ev_launch,
    output logic      ev_reject,
    output logic      ev_ok,
    output logic      ev_fail,
    output logic      ev_resume,
    output logic      rdy_n,
    output logic      err_n
);

    rd_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start_req && cfg_ok) nxt = ST_REQ;
            ST_REQ:  if (bus_gnt)             nxt = ST_ADDR;
            ST_ADDR:                          nxt = ST_DATA;
            ST_DATA: if (bus_done) begin
                         if (!bus_err && cnt_more) nxt = ST_HOLD;
                         else                      nxt = ST_IDLE;
                     end
            ST_HOLD: if (data_rd)             nxt = ST_REQ;
            default:                          nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        idle      = (state == ST_IDLE);
        bus_req   = (state == ST_REQ) || (state == ST_ADDR) || (state == ST_DATA);
        bus_start = (state == ST_ADDR);
        ev_launch = idle && start_req && cfg_ok;
        ev_reject = idle && start_req && !cfg_ok;
        ev_ok     = (state == ST_DATA) && bus_done && !bus_err;
        ev_fail   = (state == ST_DATA) && bus_done && bus_err;
        ev_resume = (state == ST_HOLD) && data_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy_n <= 1'b1;
            err_n <= 1'b1;
        end else begin
            rdy_n <= !ev_ok;
            err_n <= !(ev_fail || ev_reject);
        end
    end

    // R3: strobe covers only the first clock of the address phase
    a_r3_start_one_clk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> !bus_start);

    // R4: ready is a single-clock pulse
    a_r4_rdy_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_n |=> rdy_n);

    // R10: a rejected setup never reaches the bus
    a_r10_no_req_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
        ev_reject |=> !bus_req);

    // R7: a held run waits in place until the data read
    a_r7_hold_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !data_rd) |=> (state == ST_HOLD && !bus_req));

endmodule

// File: rtl/dbg_rd_engine.sv
module dbg_rd_engine
    import dbg_rd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_start,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [2:0]        bus_map,
    output logic [1:0]        bus_prio,
    input  logic              bus_done,
    input  logic              bus_err,
    input  logic [31:0]       bus_rdata,
    output logic              rdy_n,
    output logic              err_n
);

    rd_state_e         state;
    logic              idle, start_req, cfg_ok, data_rd, cnt_more;
    logic              ev_launch, ev_reject, ev_ok, ev_fail, ev_resume;
    logic              ac_q, dv_q, er_q;
    logic [SZ_W-1:0]   size_q;

    dbg_rd_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .rd_en(reg_rd_en), .sel(reg_sel),
        .wdata(reg_wdata), .rdata(reg_rdata), .resp_data(bus_rdata),
        .idle(idle), .ev_launch(ev_launch), .ev_reject(ev_reject),
        .ev_ok(ev_ok), .ev_fail(ev_fail), .ev_resume(ev_resume),
        .start_req(start_req), .cfg_ok(cfg_ok), .data_rd(data_rd),
        .cnt_more(cnt_more), .ac_q(ac_q), .dv_q(dv_q), .er_q(er_q),
        .addr_q(bus_addr), .size_q(size_q), .map_q(bus_map), .prio_q(bus_prio)
    );

    dbg_rd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_req(start_req), .cfg_ok(cfg_ok), .cnt_more(cnt_more),
        .data_rd(data_rd), .bus_gnt(bus_gnt), .bus_done(bus_done),
        .bus_err(bus_err), .state(state), .idle(idle),
        .bus_req(bus_req), .bus_start(bus_start),
        .ev_launch(ev_launch), .ev_reject(ev_reject), .ev_ok(ev_ok),
        .ev_fail(ev_fail), .ev_resume(ev_resume),
        .rdy_n(rdy_n), .err_n(err_n)
    );

    assign bus_size = size_q[1:0];

    // R4: pins are never low together
    a_r4_pins_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rdy_n && !err_n));

    // R4: ready pin agrees with status
    a_r4_rdy_status: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_n |-> (dv_q && !er_q));

    // R5: error pin agrees with status
    a_r5_err_status: assert property (@(posedge clk) disable iff (!rst_n)
        !err_n |-> (er_q && !dv_q && !ac_q));

    // R3: address stays put while the response is pending
    a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && !bus_done) |=> $stable(bus_addr));

endmodule

// File: tb/tb_dbg_rd_engine.sv
`timescale 1ns/1ps
module tb_dbg_rd_engine;
    import dbg_rd_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        reg_wr_en = 0, reg_rd_en = 0;
    logic [1:0]  reg_sel = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        bus_req, bus_start, bus_gnt = 0, bus_done = 0, bus_err = 0;
    logic [31:0] bus_addr, bus_rdata = 0;
    logic [1:0]  bus_size, bus_prio;
    logic [2:0]  bus_map;
    logic        rdy_n, err_n;

    dbg_rd_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_start(bus_start),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_map(bus_map),
        .bus_prio(bus_prio), .bus_done(bus_done), .bus_err(bus_err),
        .bus_rdata(bus_rdata), .rdy_n(rdy_n), .err_n(err_n)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0;
    int n_starts = 0, xfer_idx = 0, err_idx = 255, wait_cnt = 0;
    logic [31:0] cap_addr = 0;
    logic [2:0]  cap_map = 0;
    logic [1:0]  cap_prio = 0, cap_size = 0;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return a ^ 32'hA5C3_0F00;
    endfunction

    // bus responder: grant on request, response two clocks after the strobe
    always @(negedge clk) begin
        cyc++;
        bus_done = 0;
        bus_err  = 0;
        bus_gnt  = bus_req;
        if (bus_start) begin
            cap_addr = bus_addr; cap_map = bus_map; cap_prio = bus_prio;
            cap_size = bus_size; n_starts++; wait_cnt = 2;
        end else if (wait_cnt > 0) begin
            wait_cnt--;
            if (wait_cnt == 0) begin
                bus_done  = 1;
                bus_rdata = mem_word(cap_addr);
                bus_err   = (xfer_idx == err_idx);
                xfer_idx++;
            end
        end
    end

    always @(negedge clk) begin
        if (cyc == 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 0;
    endtask

    task automatic peek(input logic [1:0] s, output logic [31:0] d);
        reg_sel = s;
        #0.1;
        d = reg_rdata;
    endtask

    task automatic take_data();
        @(negedge clk);
        reg_rd_en = 1; reg_sel = SEL_DATA;
        @(negedge clk);
        reg_rd_en = 0;
    endtask

    task automatic wait_pulse(output logic got_ok, output logic got_er);
        got_ok = 0; got_er = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            #0.1;
            if (!rdy_n || !err_n) begin
                got_ok = !rdy_n; got_er = !err_n;
                break;
            end
        end
    endtask

    function automatic logic [31:0] mk_ctrl(input logic go, input logic [2:0] map,
            input logic [1:0] pr, input logic dir, input logic [2:0] sz,
            input logic [13:0] cnt);
        logic [31:0] w;
        w = '0;
        w[GO_BIT] = go; w[MAP_LSB +: 3] = map; w[PRI_LSB +: 2] = pr;
        w[DIR_BIT] = dir; w[SZ_LSB +: 3] = sz; w[CNT_LSB +: 14] = cnt;
        return w;
    endfunction

    // vector: address, size, count, failing transfer index (255 = none)
    localparam logic [56:0] VEC [6] = '{
        {32'h0000_1000, 3'd2, 14'd0, 8'd255},
        {32'h0000_2002, 3'd1, 14'd1, 8'd255},
        {32'h0000_3000, 3'd2, 14'd4, 8'd255},
        {32'h0000_4001, 3'd0, 14'd3, 8'd255},
        {32'h0000_5000, 3'd2, 14'd5, 8'd2},
        {32'h0000_6000, 3'd1, 14'd0, 8'd0}
    };

    initial begin
        logic [31:0] rd, b_addr, inc, exp_a;
        logic [2:0]  b_size;
        logic [13:0] b_cnt;
        logic [7:0]  b_err;
        logic        ok, er, failed;
        int          n;

        repeat (3) @(negedge clk);
        #0.1;
        // R1 reset state
        chk("R1 rdy_n", {31'd0, rdy_n}, 32'd1);
        chk("R1 err_n", {31'd0, err_n}, 32'd1);
        chk("R1 bus_req/start", {30'd0, bus_req, bus_start}, 32'd0);
        peek(SEL_CTRL, rd); chk("R1 control word", rd, 32'd0);
        peek(SEL_DATA, rd); chk("R1 data register", rd, 32'd0);
        rst_n = 1;

        // R2 field layout readback (no go)
        wr(SEL_CTRL, mk_ctrl(0, 3'b110, 2'b01, 0, 3'b001, 14'h2A5));
        peek(SEL_CTRL, rd);
        chk("R2 control fields", rd, mk_ctrl(0, 3'b110, 2'b01, 0, 3'b001, 14'h2A5));
        wr(SEL_ADDR, 32'hCAFE_0010);
        peek(SEL_ADDR, rd); chk("R2 address register", rd, 32'hCAFE_0010);

        // table walk
        for (int v = 0; v < 6; v++) begin
            {b_addr, b_size, b_cnt, b_err} = VEC[v];
            inc = 32'd1 << b_size[1:0];
            n = (b_cnt <= 1) ? 1 : int'(b_cnt);
            err_idx = b_err; xfer_idx = 0; n_starts = 0; failed = 0;
            wr(SEL_ADDR, b_addr);
            wr(SEL_CTRL, mk_ctrl(1, 3'b101, 2'b11, 0, b_size, b_cnt));
            for (int k = 0; k < n; k++) begin
                wait_pulse(ok, er);
                exp_a = b_addr + inc * k;
                chk("R8 bus address of transfer", cap_addr, exp_a);
                chk("R3 bus map/prio/size", {25'd0, cap_map, cap_prio, cap_size},
                    {25'd0, 3'b101, 2'b11, b_size[1:0]});
                if (k == int'(b_err)) begin
                    chk("R5 pins on error", {30'd0, ok, er}, 32'd1);
                    peek(SEL_CTRL, rd);
                    chk("R5 status ERR/DV/AC", {29'd0, rd[ERR_BIT], rd[DV_BIT], rd[GO_BIT]}, 32'd4);
                    chk("R9 count kept", {18'd0, rd[CNT_LSB +: 14]},
                        (b_cnt > k) ? 32'(b_cnt) - k : 32'd0);
                    peek(SEL_ADDR, rd);
                    chk("R9 address kept", rd, exp_a);
                    failed = 1;
                    break;
                end
                chk("R4 pins on success", {30'd0, ok, er}, 32'd2);
                peek(SEL_DATA, rd); chk("R4 data register", rd, mem_word(exp_a));
                peek(SEL_CTRL, rd);
                chk("R4 DV/ERR", {30'd0, rd[DV_BIT], rd[ERR_BIT]}, 32'd2);
                if (k < n - 1) begin
                    chk("R7 busy during run", {31'd0, rd[GO_BIT]}, 32'd1);
                    @(negedge clk); #0.1;
                    chk("R4 ready width", {31'd0, rdy_n}, 32'd1);
                    repeat (3) @(negedge clk);
                    chk("R7 no start before data read", n_starts, k + 1);
                    take_data();
                    peek(SEL_CTRL, rd);
                    chk("R7 data read clears DV", {31'd0, rd[DV_BIT]}, 32'd0);
                end else begin
                    chk("R6 busy clear after last", {31'd0, rd[GO_BIT]}, 32'd0);
                end
            end
            if (!failed) begin
                peek(SEL_ADDR, rd);
                chk("R8 final address", rd, b_addr + inc * n);
                peek(SEL_CTRL, rd);
                chk("R8 final count", {18'd0, rd[CNT_LSB +: 14]}, 32'd0);
                chk("R6 transfer total", n_starts, n);
            end
            repeat (3) @(negedge clk);
        end

        // R10 rejected setups
        n_starts = 0;
        wr(SEL_CTRL, mk_ctrl(1, 3'b000, 2'b00, 0, 3'b100, 14'd1));
        chk("R10 error pin size 100", {31'd0, err_n}, 32'd0);
        wr(SEL_CTRL, mk_ctrl(1, 3'b000, 2'b00, 0, 3'b011, 14'd1));
        chk("R10 error pin size 011", {31'd0, err_n}, 32'd0);
        wr(SEL_CTRL, mk_ctrl(1, 3'b000, 2'b00, 1, 3'b010, 14'd1));
        chk("R10 error pin write dir", {31'd0, err_n}, 32'd0);
        peek(SEL_CTRL, rd);
        chk("R10 ERR set, AC clear", {30'd0, rd[ERR_BIT], rd[GO_BIT]}, 32'd2);
        repeat (4) @(negedge clk);
        chk("R10 no bus cycle", {31'd0, bus_req}, 32'd0);
        chk("R10 no start strobe", n_starts, 0);

        // R11 stores while busy
        err_idx = 255; xfer_idx = 0; n_starts = 0;
        wr(SEL_ADDR, 32'h0000_7000);
        wr(SEL_CTRL, mk_ctrl(1, 3'b010, 2'b10, 0, 3'b010, 14'd2));
        wait_pulse(ok, er);
        wr(SEL_ADDR, 32'hDEAD_0000);
        wr(SEL_CTRL, mk_ctrl(1, 3'b111, 2'b00, 0, 3'b000, 14'd9));
        peek(SEL_ADDR, rd); chk("R11 address write ignored", rd, 32'h0000_7004);
        peek(SEL_CTRL, rd);
        chk("R11 control write ignored", {18'd0, rd[CNT_LSB +: 14]}, 32'd1);
        chk("R11 map unchanged", {29'd0, rd[MAP_LSB +: 3]}, 32'd2);
        take_data();
        wait_pulse(ok, er);
        chk("R11 second transfer address", cap_addr, 32'h0000_7004);
        chk("R11 second transfer ok", {30'd0, ok, er}, 32'd2);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule